// File: doc/BRIEF.md
# Adaptive Pruning Threshold Unit

This block derives the pruning threshold used by a bit-serial attention scorer for one query. In every bit-plane round the scoring lanes deliver one lower-bound score per candidate token. That score is the partial score plus the smallest contribution that the unseen lower bits could still add. Each beat carries a flag that says whether the token is still live. The unit keeps the largest lower bound among the live tokens of the round. When the beat marked as last of round arrives, it subtracts a scaled radius, alpha times five, and registers the result as the new threshold. The threshold goes out with a one-cycle strobe, and every lane uses it to decide which tokens to drop.

Alpha is a programmable unsigned fraction with eight fraction bits. Its product with the radius is rounded to the integer grid of the score. Because the threshold is rebuilt every round from the best guaranteed score of that round, it follows the score distribution and is not a fixed constant. A round with no live token leaves the previous threshold in place, but the strobe still fires, so that the lanes stay in step with the rounds.

Top module: `prune_thr_unit`

## Requirements
- R1: After reset, thr_valid is 0 and thr_value is the most negative score value (-32768 at the default 16-bit width).
- R2: For a round that contains live tokens, thr_value equals the largest live lower-bound score of the round minus the penalty. The penalty is round(alpha*5/256), with an exact half rounded up. The new value appears in the cycle after the last beat is accepted.
- R3: thr_valid is high for exactly one cycle, the cycle after each accepted beat that has lb_valid=1 and lb_last=1. It is low in every other cycle.
- R4: A beat with lb_live=0 does not contribute its score to the maximum, even when its score is the largest in the round.
- R5: Inputs are ignored while lb_valid=0, including a high lb_last and any score. Such cycles neither end a round nor change the maximum.
- R6: The running maximum restarts at the start of each round. A high score from an earlier round does not affect a later round.
- R7: A round in which no beat is live keeps the previous thr_value and still pulses thr_valid.
- R8: A result below the most negative score saturates to that value.
- R9: Alpha is taken on the last beat of the round. Alpha=0 gives a penalty of 0 and alpha=255 gives a penalty of 5. Changes to alpha earlier in the round have no effect.
- R10: The last beat itself counts toward the maximum when it is live, so a single-beat round is valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lb_valid | input | 1 | Beat carries a token score |
| lb_live | input | 1 | Token has not been pruned yet |
| lb_last | input | 1 | Beat closes the current round |
| lb_score | input | SCORE_W | Signed lower-bound score of the token |
| alpha | input | ALPHA_W | Unsigned fraction alpha with ALPHA_W fraction bits |
| thr_valid | output | 1 | One-cycle strobe for a new threshold |
| thr_value | output | SCORE_W | Signed threshold broadcast to the lanes |

## Verification
The hardest case to reach is a round whose last beat closes with no live token while an earlier round left a nonzero threshold. The design must then hold that value and still strobe. The stimulus runs a normal round, then a round made only of dead tokens whose scores are far higher, so that any leak of those scores would show up as a changed value. Idle cycles that carry lb_last=1 and an extreme score are placed inside a round, and alpha is changed just before the closing beat. This shows that only accepted beats, and the alpha presented with the final beat, reach the result.

// File: rtl/prune_thr_pkg.sv
package prune_thr_pkg;
  localparam int SCORE_W_DEF = 16;
  localparam int ALPHA_W_DEF = 8;
  localparam int RADIUS_DEF  = 5;
endpackage

// File: rtl/lbmax_track.sv
module lbmax_track #(
  parameter int SCORE_W = prune_thr_pkg::SCORE_W_DEF
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      in_valid,
  input  logic                      in_live,
  input  logic                      in_last,
  input  logic signed [SCORE_W-1:0] in_score,
  output logic                      close,
  output logic signed [SCORE_W-1:0] close_max,
  output logic                      close_live
);
  localparam logic signed [SCORE_W-1:0] MIN_VAL = {1'b1, {(SCORE_W-1){1'b0}}};

  logic signed [SCORE_W-1:0] run_max;
  logic                      any_live;
  logic                      take;

  function automatic logic signed [SCORE_W-1:0] pick_max(
    input logic signed [SCORE_W-1:0] a,
    input logic signed [SCORE_W-1:0] b
  );
    return (a > b) ? a : b;
  endfunction

  assign take       = in_valid && in_live;
  assign close      = in_valid && in_last;
  assign close_max  = take ? pick_max(in_score, run_max) : run_max;
  assign close_live = any_live || take;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_max  <= MIN_VAL;
      any_live <= 1'b0;
    end else if (close) begin
      run_max  <= MIN_VAL;
      any_live <= 1'b0;
    end else if (take) begin
      run_max  <= close_max;
      any_live <= 1'b1;
    end
  end

  // R4: a dead beat inside a round leaves the running state alone
  a_r4_dead_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_live && !in_last) |=> ($stable(run_max) && $stable(any_live)));

  // R5: idle cycles leave the running state alone
  a_r5_idle_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(run_max) && $stable(any_live)));

  // R6: a new round starts from the floor
  a_r6_fresh_round: assert property (@(posedge clk) disable iff (!rst_n)
    close |=> (run_max == MIN_VAL && !any_live));

  // R2: a live beat in mid-round is covered by the running max
  a_r2_max_covers: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !in_last) |=> (run_max >= $past(in_score)));
endmodule

// File: rtl/thr_scale.sv
module thr_scale #(
  parameter int ALPHA_W = prune_thr_pkg::ALPHA_W_DEF,
  parameter int RADIUS  = prune_thr_pkg::RADIUS_DEF,
  parameter int PEN_W   = $clog2(RADIUS + 1)
) (
  input  logic [ALPHA_W-1:0] alpha,
  output logic [PEN_W-1:0]   penalty
);
  localparam int PROD_W = ALPHA_W + PEN_W + 1;

  function automatic logic [PEN_W-1:0] round_penalty(input logic [ALPHA_W-1:0] a);
    logic [PROD_W-1:0] prod;
    prod = PROD_W'(a) * PROD_W'(RADIUS) + (PROD_W'(1) << (ALPHA_W - 1));
    return PEN_W'(prod >> ALPHA_W);
  endfunction

  assign penalty = round_penalty(alpha);

  // R9: the scaled radius never exceeds the radius
  always_comb begin
    a_r9_penalty_bound: assert (penalty <= PEN_W'(RADIUS));
  end
endmodule

// File: rtl/thr_out.sv
module thr_out #(
  parameter int SCORE_W = prune_thr_pkg::SCORE_W_DEF,
  parameter int PEN_W   = 3
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      close,
  input  logic signed [SCORE_W-1:0] close_max,
  input  logic                      close_live,
  input  logic [PEN_W-1:0]          penalty,
  output logic                      thr_valid,
  output logic signed [SCORE_W-1:0] thr_value
);
  localparam logic signed [SCORE_W-1:0] MIN_VAL = {1'b1, {(SCORE_W-1){1'b0}}};

  function automatic logic signed [SCORE_W-1:0] sat_sub(
    input logic signed [SCORE_W-1:0] m,
    input logic [PEN_W-1:0]          p
  );
    logic signed [SCORE_W:0] d;
    d = {m[SCORE_W-1], m} - $signed({{(SCORE_W + 1 - PEN_W){1'b0}}, p});
    if (d[SCORE_W] != d[SCORE_W-1]) return MIN_VAL;
    return d[SCORE_W-1:0];
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      thr_valid <= 1'b0;
      thr_value <= MIN_VAL;
    end else begin
      thr_valid <= close;
      if (close && close_live) thr_value <= sat_sub(close_max, penalty);
    end
  end
endmodule

// File: rtl/prune_thr_unit.sv
module prune_thr_unit #(
  parameter int SCORE_W = prune_thr_pkg::SCORE_W_DEF,
  parameter int ALPHA_W = prune_thr_pkg::ALPHA_W_DEF,
  parameter int RADIUS  = prune_thr_pkg::RADIUS_DEF
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      lb_valid,
  input  logic                      lb_live,
  input  logic                      lb_last,
  input  logic signed [SCORE_W-1:0] lb_score,
  input  logic [ALPHA_W-1:0]        alpha,
  output logic                      thr_valid,
  output logic signed [SCORE_W-1:0] thr_value
);
  localparam int PEN_W = $clog2(RADIUS + 1);

  logic                      round_close;
  logic signed [SCORE_W-1:0] round_max;
  logic                      round_live;
  logic [PEN_W-1:0]          penalty;

  lbmax_track #(.SCORE_W(SCORE_W)) u_track (
    .clk(clk), .rst_n(rst_n),
    .in_valid(lb_valid), .in_live(lb_live), .in_last(lb_last), .in_score(lb_score),
    .close(round_close), .close_max(round_max), .close_live(round_live)
  );

  thr_scale #(.ALPHA_W(ALPHA_W), .RADIUS(RADIUS), .PEN_W(PEN_W)) u_scale (
    .alpha(alpha), .penalty(penalty)
  );

  thr_out #(.SCORE_W(SCORE_W), .PEN_W(PEN_W)) u_out (
    .clk(clk), .rst_n(rst_n),
    .close(round_close), .close_max(round_max), .close_live(round_live),
    .penalty(penalty), .thr_valid(thr_valid), .thr_value(thr_value)
  );

  // R3: each accepted closing beat yields a strobe next cycle
  a_r3_strobe_on_close: assert property (@(posedge clk) disable iff (!rst_n)
    (lb_valid && lb_last) |=> thr_valid);

  // R3: no strobe without a closing beat
  a_r3_no_stray_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !(lb_valid && lb_last) |=> !thr_valid);

  // R7: an empty round holds the threshold
  a_r7_hold_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (round_close && !round_live) |=> $stable(thr_value));

  // R2: the threshold never rises above the round maximum
  a_r2_not_above_max: assert property (@(posedge clk) disable iff (!rst_n)
    (round_close && round_live) |=> (thr_value <= $past(round_max)));

  // R6: the threshold only moves after a closing beat
  a_r6_only_on_close: assert property (@(posedge clk) disable iff (!rst_n)
    !(lb_valid && lb_last) |=> $stable(thr_value));
endmodule

// File: tb/prune_thr_unit_test.sv
module prune_thr_unit_test;
  localparam int CLK_PERIOD = 10;
  localparam int SW = 16;
  localparam int MINV = -32768;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lb_valid = 1'b0, lb_live = 1'b0, lb_last = 1'b0;
  logic signed [SW-1:0] lb_score = '0;
  logic [7:0] alpha = '0;
  logic thr_valid;
  logic signed [SW-1:0] thr_value;

  int checks = 0, fails = 0;
  int exp_q[$];
  string tag_q[$];
  int b_max, prev_thr, expected_pulses, seen_pulses;
  bit b_live, done;

  always #(CLK_PERIOD/2) clk = ~clk;

  prune_thr_unit uut (
    .clk(clk), .rst_n(rst_n), .lb_valid(lb_valid), .lb_live(lb_live),
    .lb_last(lb_last), .lb_score(lb_score), .alpha(alpha),
    .thr_valid(thr_valid), .thr_value(thr_value)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int model_pen(input int a);
    int q, p;
    q = a * 5;
    p = q / 256;
    if ((q % 256) >= 128) p = p + 1;
    return p;
  endfunction

  task automatic beat(input int score, input bit live, input bit last, input int a, input string tag);
    @(posedge clk) #1;
    lb_valid = 1'b1; lb_live = live; lb_last = last; lb_score = SW'(score); alpha = 8'(a);
    if (live) begin
      if (!b_live || score > b_max) b_max = score;
      b_live = 1'b1;
    end
    if (last) begin
      int e;
      if (b_live) begin
        e = b_max - model_pen(a);
        if (e < MINV) e = MINV;
      end else e = prev_thr;
      prev_thr = e;
      exp_q.push_back(e);
      tag_q.push_back(tag);
      expected_pulses++;
      b_live = 1'b0;
    end
  endtask

  task automatic idle(input int score, input bit last);
    @(posedge clk) #1;
    lb_valid = 1'b0; lb_live = 1'b1; lb_last = last; lb_score = SW'(score); alpha = 8'd255;
  endtask

  always @(negedge clk) begin
    if (rst_n && thr_valid) begin
      seen_pulses++;
      if (exp_q.size() == 0) begin
        check("R3 stray strobe", 1, 0);
      end else begin
        int e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, int'(thr_value), e);
      end
    end
  end

  task automatic finish_run;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      check("watchdog", 0, 1);
      finish_run();
    end
  end

  initial begin
    prev_thr = MINV; b_live = 1'b0; b_max = 0;
    expected_pulses = 0; seen_pulses = 0; done = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset valid", int'(thr_valid), 0);
    check("R1 reset value", int'(thr_value), MINV);

    // R2: max 40, alpha 128 -> penalty 3 (half rounds up)
    beat(10, 1, 0, 128, "R2");
    beat(-3, 1, 0, 128, "R2");
    beat(40, 1, 0, 128, "R2");
    beat(7, 1, 1, 128, "R2 max minus penalty");
    // R4: dead high score ignored, alpha 0 -> 20; back-to-back round
    beat(100, 0, 0, 0, "R4");
    beat(20, 1, 0, 0, "R4");
    beat(5, 1, 1, 0, "R4 dead token ignored");
    // R5: idle cycles carrying last and huge score; alpha 255 -> penalty 5
    beat(50, 1, 0, 255, "R5");
    idle(30000, 1);
    idle(-20000, 1);
    beat(12, 1, 1, 255, "R5 idle beats ignored");
    // R6: lower scores after a round with 50
    beat(-100, 1, 0, 0, "R6");
    beat(-50, 1, 1, 0, "R6 max restarts per round");
    // R7: all dead round holds -50
    beat(1000, 0, 0, 0, "R7");
    beat(2000, 0, 1, 200, "R7 empty round holds");
    idle(0, 0);
    // R10: single-beat round, alpha 51 -> penalty 1
    beat(-7, 1, 1, 51, "R10 single beat");
    // R8: saturation
    beat(-32767, 1, 1, 255, "R8 saturate");
    beat(-32768, 1, 1, 0, "R8 floor alpha zero");
    // R9: alpha changes mid-round, last beat uses alpha 0
    beat(300, 1, 0, 255, "R9");
    beat(200, 1, 1, 0, "R9 alpha sampled at last");
    // R9: alpha 255 gives penalty 5
    beat(300, 1, 0, 0, "R9");
    beat(-1, 1, 1, 255, "R9 full alpha");
    idle(0, 0);
    repeat (4) @(posedge clk);
    @(negedge clk);
    check("R7 value held after strobe", int'(thr_value), prev_thr);
    check("R3 strobe count", seen_pulses, expected_pulses);
    check("R3 no pending", exp_q.size(), 0);
    done = 1'b1;
    finish_run();
  end
endmodule